// File: doc/BRIEF.md
# Configuration-Selected Clock Output Router

This block takes six candidate clocks (four PLL clocks, a MHz reference and a 32 kHz reference) and routes them onto seven output pins plus one extra leg that pairs with output 6. Each output has its own source selector, an 8-bit divider, an invert bit, an enable bit and a power bit. The settings come from one of three configuration banks. A two-pin select input picks the bank. The remaining select code puts the block into power-down, or into a sleep state that keeps the 32 kHz clock alive on one fixed pin.

All clock inputs are treated as level signals and are oversampled by `clk_i`. The select pins pass through a two-flop synchroniser before use. Each output's divider follows a source change or a divide change only at the end of a divide period, so an output never shows a shortened pulse when it is reprogrammed. Each leg ends in a register that produces the pin value and a tristate enable.

Top module: `clk_route_top`

## Requirements
- R1: Select code 01 applies bank 0, code 10 applies bank 1 and code 11 applies bank 2. A new select value governs the outputs from the third rising edge of `clk_i` after it is presented: two synchroniser stages, then the output register.
- R2: With select 00 and `keep_rtc_i`=0, all eight legs are driven low (`oe_o`=1, `clk_o`=0).
- R3: With select 00 and `keep_rtc_i`=1, leg 4 carries `rtc_i` through one register, with no divider and no inversion. The other legs are driven low, and all eight legs have `oe_o`=1.
- R4: A source code of 00 holds that leg driven low (`oe_o`=1, `clk_o`=0) whatever its invert bit.
- R5: Source codes 01/10/11 select, per output (`pll_i` bit k is PLL k):
  - out0: PLL0 / PLL1 / ref
  - out1: PLL1 / PLL2 / ref
  - out2: PLL0 / rtc / PLL3
  - out3: ref / rtc / PLL3
  - out4: PLL2 / ref / rtc
  - out5: PLL1 / PLL3 / ref
  - out6: PLL0 / PLL1 / PLL2
- R6: A divide value D of 2 or more gives one output rising edge per D rising edges of the source. A value of 0 or 1 passes the source straight through.
- R7: Power bit 0 gives a leg driven low. Power bit 1 with enable bit 0 gives a tristated leg (`oe_o`=0, `clk_o`=0). Both bits 1 give an active leg.
- R8: The invert bit complements the clock on an active leg.
- R9: Leg 7 (second leg of output 6) carries output 6's divided clock. It has its own enable and invert bits and shares output 6's power bit.
- R10: A new source or divide value for an output is taken at the source rising edge that completes the current divide period. If the output's current source code is 00, the new value is taken at once.
- R11: Bank b occupies `cfg_i[b*93 +: 93]`. Inside a bank, output o occupies bits o*13 onward: [1:0] source, [9:2] divide, [10] invert, [11] enable, [12] power. Bank bit 91 is leg 7's enable and bank bit 92 is leg 7's invert.
- R12: While `rst_ni` is low, `clk_o` and `oe_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling and state clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pll_i | input | 4 | PLL clocks 0 to 3 |
| ref_i | input | 1 | MHz reference clock |
| rtc_i | input | 1 | 32 kHz reference clock |
| sel_i | input | 2 | Bank select / power-down pins |
| keep_rtc_i | input | 1 | In select 00: 1 = sleep with 32 kHz on leg 4, 0 = full power-down |
| cfg_i | input | 279 | Three flattened configuration banks |
| clk_o | output | 8 | Leg clock values (legs 0..6, leg 7 = second leg of output 6) |
| oe_o | output | 8 | Per-leg driver enable (0 = tristate) |

## Verification
Every source has a distinct period: 4, 6, 8, 10, 12 and 14 cycles for PLL0 to PLL3, ref and rtc. Counting output rising edges over an 840-cycle window therefore tells which source was routed and which divide value was applied. Each vector programmes only the bank its select code names and leaves the other banks powered down. A wrong bank therefore reads as zero edges, and a wrong encoding or divide gives a different count. Static cases use frozen PLL inputs to separate inversion, the leg-7 controls and the power/enable table from the divider. A mid-period divide change that must produce no edge until the current period ends shows whether the update waits for the terminal count.

// File: rtl/clk_route_pkg.sv
package clk_route_pkg;
  localparam int N_OUT       = 7;
  localparam int N_LEG       = N_OUT + 1;
  localparam int N_BANK      = 3;
  localparam int N_SRC       = 6;
  localparam int DIV_W       = 8;
  localparam int SEL_W       = 2;
  localparam int SYNC_STAGES = 2;
  localparam int SLEEP_LEG   = 4;

  localparam int F_DIV  = SEL_W;
  localparam int F_INV  = F_DIV + DIV_W;
  localparam int F_EN   = F_INV + 1;
  localparam int F_PWR  = F_EN + 1;
  localparam int FLD_W  = F_PWR + 1;
  localparam int B_EN2  = N_OUT * FLD_W;
  localparam int B_INV2 = B_EN2 + 1;
  localparam int BANK_W = B_INV2 + 1;
  localparam int CFG_W  = N_BANK * BANK_W;

  typedef struct packed {
    logic             pwr;
    logic             en;
    logic             inv;
    logic [DIV_W-1:0] div;
    logic [SEL_W-1:0] src;
  } fld_t;

  typedef enum logic [2:0] {
    SRC_P0, SRC_P1, SRC_P2, SRC_P3, SRC_REF, SRC_RTC
  } src_e;

  // per-output source encoding; code 0 is "off" and never reaches here
  function automatic src_e src_of(input int o, input logic [SEL_W-1:0] code);
    src_e s;
    s = SRC_P0;
    case (o)
      0: s = (code == 2'b01) ? SRC_P0  : (code == 2'b10) ? SRC_P1  : SRC_REF;
      1: s = (code == 2'b01) ? SRC_P1  : (code == 2'b10) ? SRC_P2  : SRC_REF;
      2: s = (code == 2'b01) ? SRC_P0  : (code == 2'b10) ? SRC_RTC : SRC_P3;
      3: s = (code == 2'b01) ? SRC_REF : (code == 2'b10) ? SRC_RTC : SRC_P3;
      4: s = (code == 2'b01) ? SRC_P2  : (code == 2'b10) ? SRC_REF : SRC_RTC;
      5: s = (code == 2'b01) ? SRC_P1  : (code == 2'b10) ? SRC_P3  : SRC_REF;
      default: s = (code == 2'b01) ? SRC_P0 : (code == 2'b10) ? SRC_P1 : SRC_P2;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/clk_route_sync.sv
module clk_route_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/clk_route_div.sv
module clk_route_div import clk_route_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_i,
  input  logic [SEL_W-1:0] sel_new_i,
  input  logic [DIV_W-1:0] div_new_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             clk_o
);
  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] div_q, cnt_q, cnt_nxt;
  logic             src_q, phase_q, off, pass, rise, tc;

  assign off     = (sel_q == '0);
  assign pass    = (div_q <= DIV_W'(1));
  assign rise    = src_i & ~src_q;
  assign tc      = rise & (pass | (cnt_q == div_q - DIV_W'(1)));
  assign cnt_nxt = tc ? '0 : cnt_q + DIV_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      div_q   <= '0;
      cnt_q   <= '0;
      src_q   <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      src_q <= src_i;
      // shadow update only at period end (or while idle)
      if (off || tc) begin
        sel_q <= sel_new_i;
        div_q <= div_new_i;
      end
      if (off) begin
        cnt_q   <= '0;
        phase_q <= 1'b0;
      end else if (rise) begin
        cnt_q   <= cnt_nxt;
        phase_q <= pass | (cnt_nxt < (div_q >> 1));
      end
    end
  end

  assign sel_o = sel_q;
  assign clk_o = off ? 1'b0 : (pass ? src_q : phase_q);
endmodule

// File: rtl/clk_route_leg.sv
module clk_route_leg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  input  logic sleep_clk_i,
  input  logic pwr_i,
  input  logic en_i,
  input  logic inv_i,
  input  logic off_i,
  input  logic clk_src_i,
  output logic clk_o,
  output logic oe_o
);
  logic clk_n, oe_n;

  always_comb begin
    oe_n  = 1'b1;
    clk_n = 1'b0;
    if (sleep_i)       clk_n = sleep_clk_i;
    else if (!pwr_i)   clk_n = 1'b0;
    else if (!en_i)    oe_n  = 1'b0;
    else if (off_i)    clk_n = 1'b0;
    else               clk_n = clk_src_i ^ inv_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_o <= 1'b0;
      oe_o  <= 1'b0;
    end else begin
      clk_o <= clk_n;
      oe_o  <= oe_n;
    end
  end
endmodule

// File: rtl/clk_route_top.sv
module clk_route_top import clk_route_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       pll_i,
  input  logic             ref_i,
  input  logic             rtc_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             keep_rtc_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic [N_LEG-1:0] clk_o,
  output logic [N_LEG-1:0] oe_o
);
  logic [SEL_W-1:0]  sel_s;
  logic              sleep;
  logic [N_SRC-1:0]  srcs;
  logic [BANK_W-1:0] banks [N_BANK];
  logic [BANK_W-1:0] act_bank;
  fld_t              fld      [N_OUT];
  logic [SEL_W-1:0]  act_sel  [N_OUT];
  logic [N_OUT-1:0]  src_now, div_clk, off;

  clk_route_sync #(.W(SEL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sel_i),
    .q_o   (sel_s)
  );

  assign sleep = (sel_s == '0);
  assign srcs  = {rtc_i, ref_i, pll_i};

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    assign banks[b] = cfg_i[b*BANK_W +: BANK_W];
  end

  always_comb begin
    case (sel_s)
      2'b01:   act_bank = banks[0];
      2'b10:   act_bank = banks[1];
      2'b11:   act_bank = banks[2];
      default: act_bank = '0;
    endcase
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    assign fld[o] = act_bank[o*FLD_W +: FLD_W];
    assign off[o] = (act_sel[o] == '0);

    always_comb begin
      if (act_sel[o] == '0) src_now[o] = 1'b0;
      else                  src_now[o] = srcs[src_of(o, act_sel[o])];
    end

    clk_route_div u_div (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (src_now[o]),
      .sel_new_i(fld[o].src),
      .div_new_i(fld[o].div),
      .sel_o    (act_sel[o]),
      .clk_o    (div_clk[o])
    );
  end

  for (genvar l = 0; l < N_LEG; l++) begin : g_leg
    localparam int O = (l < N_OUT) ? l : N_OUT - 1;
    logic en, inv, slp_clk;

    if (l < N_OUT) begin : g_main
      assign en  = fld[O].en;
      assign inv = fld[O].inv;
    end else begin : g_pair
      assign en  = act_bank[B_EN2];
      assign inv = act_bank[B_INV2];
    end

    if (l == SLEEP_LEG) begin : g_tap
      assign slp_clk = keep_rtc_i & rtc_i;
    end else begin : g_notap
      assign slp_clk = 1'b0;
    end

    clk_route_leg u_leg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sleep_i    (sleep),
      .sleep_clk_i(slp_clk),
      .pwr_i      (fld[O].pwr),
      .en_i       (en),
      .inv_i      (inv),
      .off_i      (off[O]),
      .clk_src_i  (div_clk[O]),
      .clk_o      (clk_o[l]),
      .oe_o       (oe_o[l])
    );
  end
endmodule

// File: rtl/clk_route_chk.sv
module clk_route_chk import clk_route_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SEL_W-1:0]  sel_i,
  input logic              keep_rtc_i,
  input logic [N_BANK-1:0] pwr0_i,
  input logic [N_LEG-1:0]  clk_o,
  input logic [N_LEG-1:0]  oe_o
);
  logic [2:0] age_q;
  logic       ready;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              age_q <= '0;
    else if (age_q != 3'd7)   age_q <= age_q + 3'd1;
  end
  assign ready = (age_q >= 3'd4);

  assert_pd_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready && $past(sel_i, 3) == 2'b00 && !$past(keep_rtc_i) |-> clk_o == '0 && oe_o == '1);

  assert_sleep_tap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready && $past(sel_i, 3) == 2'b00 && $past(keep_rtc_i)
    |-> (clk_o & ~(N_LEG'(1) << SLEEP_LEG)) == '0 && oe_o == '1);

  assert_tristate_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_o & ~oe_o) == '0);

  for (genvar b = 0; b < N_BANK; b++) begin : g_bk
    assert_bank_pwr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready && $past(sel_i, 3) == SEL_W'(b + 1) && !$past(pwr0_i[b])
      |-> !clk_o[0] && oe_o[0]);
  end

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_R12: assert (clk_o == '0 && oe_o == '0);
    end
  end
endmodule

bind clk_route_top clk_route_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_i     (sel_i),
  .keep_rtc_i(keep_rtc_i),
  .pwr0_i    ({cfg_i[2*BANK_W+F_PWR], cfg_i[BANK_W+F_PWR], cfg_i[F_PWR]}),
  .clk_o     (clk_o),
  .oe_o      (oe_o)
);

// File: tb/sim_clk_route_top.sv
`timescale 1ns/1ps
module sim_clk_route_top;
  localparam int FW  = 13;
  localparam int BW  = 93;
  localparam int CW  = 3 * BW;
  localparam int WIN = 840;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    frz = 4'b0;
  logic [3:0]    pll;
  logic          refc, rtc;
  logic [1:0]    sel = 2'b01;
  logic          keep = 1'b0;
  logic [CW-1:0] cfg = '0;
  logic [7:0]    clk_o, oe_o;
  int            cyc = 0;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 0;

  always #5 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;

  assign pll[0] = frz[0] | ((cyc % 4)  < 2);
  assign pll[1] = frz[1] | ((cyc % 6)  < 3);
  assign pll[2] = frz[2] | ((cyc % 8)  < 4);
  assign pll[3] = frz[3] | ((cyc % 10) < 5);
  assign refc   = (cyc % 12) < 6;
  assign rtc    = (cyc % 14) < 7;

  clk_route_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .pll_i(pll), .ref_i(refc), .rtc_i(rtc),
    .sel_i(sel), .keep_rtc_i(keep), .cfg_i(cfg), .clk_o(clk_o), .oe_o(oe_o)
  );

  // {sel, leg, code, div, expected rising edges in WIN}
  localparam logic [24:0] VEC [12] = '{
    {2'b01, 3'd0, 2'b01, 8'd0, 10'd210},
    {2'b10, 3'd1, 2'b10, 8'd3, 10'd35},
    {2'b11, 3'd3, 2'b01, 8'd5, 10'd14},
    {2'b01, 3'd3, 2'b10, 8'd2, 10'd30},
    {2'b10, 3'd3, 2'b11, 8'd1, 10'd84},
    {2'b11, 3'd4, 2'b01, 8'd5, 10'd21},
    {2'b01, 3'd4, 2'b10, 8'd7, 10'd10},
    {2'b10, 3'd4, 2'b11, 8'd3, 10'd20},
    {2'b11, 3'd5, 2'b10, 8'd4, 10'd21},
    {2'b01, 3'd6, 2'b11, 8'd7, 10'd15},
    {2'b10, 3'd2, 2'b11, 8'd6, 10'd14},
    {2'b11, 3'd7, 2'b01, 8'd2, 10'd105}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input int b, input int o, input logic [1:0] src, input logic [7:0] div,
                     input bit inv, input bit en, input bit pwr);
    int base;
    base = b * BW + o * FW;
    cfg[base +: 2]     = src;
    cfg[base + 2 +: 8] = div;
    cfg[base + 10]     = inv;
    cfg[base + 11]     = en;
    cfg[base + 12]     = pwr;
  endtask

  task automatic count_rise(input int leg, input int ncyc, output int n);
    logic prev;
    @(negedge clk);
    prev = clk_o[leg];
    n = 0;
    repeat (ncyc) begin
      @(negedge clk);
      if (clk_o[leg] && !prev) n++;
      prev = clk_o[leg];
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int n;
    int b;
    int leg;
    int exp;
    // R12 reset state
    wait_cyc(4);
    chk(clk_o == 8'h00 && oe_o == 8'h00, "R12 reset", {clk_o, oe_o}, 0);
    rst_n = 1'b1;
    wait_cyc(5);

    // R1 R5 R6 R9 R11: bank / encoding / divide vectors
    for (int i = 0; i < 12; i++) begin
      cfg = '0;
      b   = int'(VEC[i][24:23]) - 1;
      leg = int'(VEC[i][22:20]);
      exp = int'(VEC[i][9:0]);
      if (leg == 7) begin
        put(b, 6, VEC[i][19:18], VEC[i][17:10], 1'b0, 1'b0, 1'b1);
        cfg[b * BW + 91] = 1'b1;
      end else begin
        put(b, leg, VEC[i][19:18], VEC[i][17:10], 1'b0, 1'b1, 1'b1);
      end
      sel = VEC[i][24:23];
      wait_cyc(250);
      count_rise(leg, WIN, n);
      chk(n >= exp - 1 && n <= exp + 1, $sformatf("R1/R5/R6/R11 vector %0d (R9 on leg 7)", i), n, exp);
    end

    // R1 select latency: bank0 leg0 tristated, bank1 leg0 driven low
    cfg = '0;
    put(0, 0, 2'b00, 8'd0, 1'b0, 1'b0, 1'b1);
    put(1, 0, 2'b00, 8'd0, 1'b0, 1'b1, 1'b0);
    sel = 2'b01;
    wait_cyc(20);
    sel = 2'b10;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(oe_o[0] == 1'b0, "R1 before third edge", oe_o[0], 0);
    @(posedge clk); @(negedge clk);
    chk(oe_o[0] == 1'b1, "R1 after third edge", oe_o[0], 1);

    // R7 power / enable table
    cfg = '0;
    sel = 2'b01;
    put(0, 0, 2'b01, 8'd0, 1'b0, 1'b0, 1'b1);
    wait_cyc(20);
    chk(oe_o[0] == 1'b0 && clk_o[0] == 1'b0, "R7 tristate", {oe_o[0], clk_o[0]}, 0);
    put(0, 0, 2'b01, 8'd0, 1'b0, 1'b1, 1'b0);
    wait_cyc(10);
    count_rise(0, 100, n);
    chk(n == 0 && oe_o[0] == 1'b1, "R7 power bit 0 driven low", n, 0);
    put(0, 0, 2'b01, 8'd0, 1'b0, 1'b0, 1'b0);
    wait_cyc(10);
    chk(oe_o[0] == 1'b1 && clk_o[0] == 1'b0, "R7 both bits 0", {oe_o[0], clk_o[0]}, 2);

    // R4 source off ignores invert
    put(0, 0, 2'b00, 8'd0, 1'b1, 1'b1, 1'b1);
    wait_cyc(200);
    count_rise(0, 60, n);
    chk(n == 0 && clk_o[0] == 1'b0 && oe_o[0] == 1'b1, "R4 source off", {n, clk_o[0]}, 0);

    // R8 invert with PLL3 frozen high on out3
    cfg = '0;
    put(0, 3, 2'b11, 8'd0, 1'b0, 1'b1, 1'b1);
    wait_cyc(200);
    frz[3] = 1'b1;
    wait_cyc(10);
    chk(clk_o[3] == 1'b1, "R8 non-inverted", clk_o[3], 1);
    put(0, 3, 2'b11, 8'd0, 1'b1, 1'b1, 1'b1);
    wait_cyc(5);
    chk(clk_o[3] == 1'b0, "R8 inverted", clk_o[3], 0);
    frz[3] = 1'b0;

    // R9 leg 7 own invert and enable, PLL2 frozen high on out6
    cfg = '0;
    put(0, 6, 2'b11, 8'd0, 1'b0, 1'b1, 1'b1);
    cfg[91] = 1'b1;
    cfg[92] = 1'b1;
    wait_cyc(200);
    frz[2] = 1'b1;
    wait_cyc(10);
    chk(clk_o[6] == 1'b1, "R9 leg 6 clock", clk_o[6], 1);
    chk(clk_o[7] == 1'b0 && oe_o[7] == 1'b1, "R9 leg 7 inverted", clk_o[7], 0);
    cfg[91] = 1'b0;
    wait_cyc(5);
    chk(oe_o[7] == 1'b0 && oe_o[6] == 1'b1, "R9 leg 7 own enable", {oe_o[7], oe_o[6]}, 1);
    frz[2] = 1'b0;

    // R10 divide change waits for terminal count (out3 rtc /7 -> /1)
    cfg = '0;
    put(0, 3, 2'b10, 8'd7, 1'b0, 1'b1, 1'b1);
    wait_cyc(300);
    begin
      logic prev;
      int guard;
      prev = clk_o[3];
      guard = 0;
      while (guard < 300) begin
        @(negedge clk);
        guard++;
        if (clk_o[3] && !prev) break;
        prev = clk_o[3];
      end
    end
    put(0, 3, 2'b10, 8'd1, 1'b0, 1'b1, 1'b1);
    count_rise(3, 80, n);
    chk(n == 0, "R10 no early update", n, 0);
    wait_cyc(150);
    count_rise(3, WIN, n);
    chk(n >= 59 && n <= 61, "R10 new divide applied", n, 60);

    // R2 power-down
    keep = 1'b0;
    sel  = 2'b00;
    wait_cyc(10);
    count_rise(4, 100, n);
    chk(n == 0, "R2 leg 4 silent", n, 0);
    chk(clk_o == 8'h00 && oe_o == 8'hFF, "R2 all driven low", {clk_o, oe_o}, 16'h00FF);

    // R3 sleep with rtc on leg 4
    keep = 1'b1;
    wait_cyc(10);
    count_rise(4, WIN, n);
    chk(n >= 59 && n <= 61, "R3 rtc on leg 4", n, 60);
    chk((clk_o & 8'hEF) == 8'h00 && oe_o == 8'hFF, "R3 other legs low", {clk_o & 8'hEF, oe_o}, 16'h00FF);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule